// File: doc/BRIEF.md
# Switching Activity Monitor

This block watches a data bus inside a cipher datapath and measures how much it switches during one operation. An operation is framed by a start strobe and an end strobe. On every cycle between them the block counts how many bus bits changed since the previous cycle and adds that number to a running total. When the end strobe arrives, it compares the total against a fixed fraction of the largest count the window could reach. A total at or above that fraction means the switching depends on the data, so the block raises a flag that stays up until reset.

The block can also pad the switching. A dummy register, as wide as the bus, flips every bit that the bus left unchanged in that cycle. The bus and the padding together then switch a constant number of bits per cycle, whatever the data. The operation is nominally eleven cycles long. The count limit and the threshold are derived from that length and from the bus width when the block is elaborated.

Top module: `switching_monitor`

## Requirements
- R1: After reset, total_o, total_valid_o, not_secure_o and dummy_o are all zero.
- R2: A clock edge with load_i high clears the total, captures bus_i as the reference value and opens the window. If done_i is high in the same cycle, load_i takes priority, the window opens and no pulse follows.
- R3: On each edge with the window open and load_i low, the total grows by the number of bit positions in which bus_i differs from the value sampled on the previous edge, and that sample becomes the new reference.
- R4: The cycle in which done_i is high is still counted. The window then closes, and total_o holds its value until the next load, however bus_i changes.
- R5: total_valid_o is high for exactly the one cycle after the edge at which done_i closes an open window. done_i while the window is closed has no effect.
- R6: The threshold is floor(WIDTH*OP_CYCLES/10), which is 8 with the defaults. not_secure_o rises in the same cycle as total_valid_o when the final total is at least the threshold, and stays low when the total is below it.
- R7: Once set, not_secure_o stays high until rst_ni is asserted, through later windows of any total.
- R8: The total saturates at WIDTH*OP_CYCLES (88 with the defaults) and never wraps.
- R9: With balancing enabled (the default), every counted edge inverts in dummy_o exactly the bits that did not change on the bus, so bus and dummy changes add up to WIDTH. dummy_o holds its value on every other edge.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start of operation; opens the window |
| done_i | input | 1 | End of operation; closes the window |
| bus_i | input | WIDTH | Monitored bus |
| total_o | output | CNT_W | Accumulated transition count |
| total_valid_o | output | 1 | One-cycle pulse when the window closes |
| not_secure_o | output | 1 | Sticky flag for data-dependent switching |
| dummy_o | output | WIDTH | Balancing toggle register |

## Verification
If the reference register is stale, total_o is wrong after the first counted edge of a window. If the window state is wrong, the total either keeps moving after done or a pulse appears for a done outside any window, and both show up one cycle after the faulty edge. A threshold that is off by one shows up only in windows whose total sits exactly at or just below the threshold, so the bench runs windows of 7 and 8 before any window sets the sticky flag. The bench checks every counted cycle: the bits that changed in dummy_o must exactly complement the bus changes.

// File: rtl/smon_pkg.sv
package smon_pkg;
  typedef enum logic {WIN_IDLE = 1'b0, WIN_OPEN = 1'b1} win_state_e;

  function automatic int unsigned max_trans(int unsigned width, int unsigned cycles);
    return width * cycles;
  endfunction
endpackage

// File: rtl/smon_window.sv
module smon_window
  import smon_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic done_i,
  output logic open_o,
  output logic step_o,
  output logic close_o,
  output logic valid_o
);
  win_state_e state_q, state_d;
  logic       valid_q;

  assign open_o  = (state_q == WIN_OPEN);
  assign step_o  = open_o && !load_i;
  assign close_o = step_o && done_i;

  always_comb begin
    state_d = state_q;
    if (load_i)       state_d = WIN_OPEN;
    else if (close_o) state_d = WIN_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WIN_IDLE;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= close_o;
    end
  end

  assign valid_o = valid_q;

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R5
  idle_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WIN_IDLE && !load_i) |=> !valid_q);

  // R2
  load_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (state_q == WIN_OPEN) && !valid_q);
endmodule

// File: rtl/smon_hamming.sv
module smon_hamming #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned HD_W = $clog2(WIDTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] diff_o,
  output logic [HD_W-1:0]  hd_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        prev_q <= '0;
    else if (capture_i) prev_q <= bus_i;
  end

  assign diff_o = bus_i ^ prev_q;

  always_comb begin
    hd_o = '0;
    for (int i = 0; i < int'(WIDTH); i++) hd_o = hd_o + HD_W'(diff_o[i]);
  end

  // R3
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(prev_q));
endmodule

// File: rtl/smon_balancer.sv
module smon_balancer #(
  parameter int unsigned WIDTH      = 8,
  parameter bit          BALANCE_EN = 1'b1,
  localparam int unsigned HD_W      = $clog2(WIDTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [WIDTH-1:0] diff_i,
  input  logic [HD_W-1:0]  hd_i,
  output logic [WIDTH-1:0] dummy_o
);
  if (BALANCE_EN) begin : g_bal
    logic [WIDTH-1:0] dummy_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dummy_q <= '0;
      else if (step_i) dummy_q <= dummy_q ^ ~diff_i;
    end

    assign dummy_o = dummy_q;

    // R9
    balance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i |=> ($countones(dummy_q ^ $past(dummy_q)) + int'($past(hd_i))) == int'(WIDTH));

    // R9
    dummy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !step_i |=> $stable(dummy_q));
  end else begin : g_nobal
    assign dummy_o = '0;
  end
endmodule

// File: rtl/switching_monitor.sv
module switching_monitor
  import smon_pkg::*;
#(
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned OP_CYCLES  = 11,
  parameter bit          BALANCE_EN = 1'b1,
  localparam int unsigned MAX_TRANS = max_trans(WIDTH, OP_CYCLES),
  localparam int unsigned THRESH    = MAX_TRANS / 10,
  localparam int unsigned CNT_W     = $clog2(MAX_TRANS + 1),
  localparam int unsigned HD_W      = $clog2(WIDTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             done_i,
  input  logic [WIDTH-1:0] bus_i,
  output logic [CNT_W-1:0] total_o,
  output logic             total_valid_o,
  output logic             not_secure_o,
  output logic [WIDTH-1:0] dummy_o
);
  localparam logic [CNT_W:0] MAX_EXT    = (CNT_W+1)'(MAX_TRANS);
  localparam logic [CNT_W:0] THRESH_EXT = (CNT_W+1)'(THRESH);

  logic             win_open, step, close;
  logic [WIDTH-1:0] diff;
  logic [HD_W-1:0]  hd;
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W:0]   acc_sum;
  logic [CNT_W-1:0] acc_sat;
  logic             flag_q;

  smon_window u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .done_i  (done_i),
    .open_o  (win_open),
    .step_o  (step),
    .close_o (close),
    .valid_o (total_valid_o)
  );

  smon_hamming #(.WIDTH(WIDTH)) u_hamming (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (load_i | step),
    .bus_i     (bus_i),
    .diff_o    (diff),
    .hd_o      (hd)
  );

  smon_balancer #(.WIDTH(WIDTH), .BALANCE_EN(BALANCE_EN)) u_balancer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .diff_i  (diff),
    .hd_i    (hd),
    .dummy_o (dummy_o)
  );

  assign acc_sum = {1'b0, acc_q} + (CNT_W+1)'(hd);
  assign acc_sat = (acc_sum > MAX_EXT) ? MAX_EXT[CNT_W-1:0] : acc_sum[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (load_i)    acc_q <= '0;
      else if (step) acc_q <= acc_sat;
      // sticky: only reset clears it
      if (close && ({1'b0, acc_sat} >= THRESH_EXT)) flag_q <= 1'b1;
    end
  end

  assign total_o      = acc_q;
  assign not_secure_o = flag_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, acc_q} <= MAX_EXT);

  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_secure_o |=> not_secure_o);

  // R6
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(not_secure_o) |-> total_valid_o && ({1'b0, total_o} >= THRESH_EXT));

  // R4
  total_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_open && !load_i) |=> $stable(acc_q));

  // R2
  load_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (acc_q == '0));
endmodule

// File: tb/switching_monitor_test.sv
`timescale 1ns/1ps
module switching_monitor_test;
  localparam int unsigned W     = 8;
  localparam int unsigned OPC   = 11;
  localparam int unsigned MAXT  = W * OPC;
  localparam int unsigned THR   = MAXT / 10;
  localparam int unsigned CW    = $clog2(MAXT + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load = 1'b0, done = 1'b0;
  logic [W-1:0]  bus = '0;
  logic [CW-1:0] total;
  logic          tvalid, nsec;
  logic [W-1:0]  dummy;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  // model state
  logic [W-1:0] m_prev = '0, m_dummy = '0, m_last_dummy = '0, m_last_bus = '0;
  int           m_acc = 0;
  bit           m_open = 0, m_valid = 0, m_flag = 0, m_counted = 0;

  switching_monitor uut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load), .done_i(done), .bus_i(bus),
    .total_o(total), .total_valid_o(tvalid), .not_secure_o(nsec), .dummy_o(dummy)
  );

  always #5 clk = ~clk;

  function automatic int popc(input logic [W-1:0] v);
    int c = 0;
    for (int i = 0; i < int'(W); i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit l, input bit d, input logic [W-1:0] b, input string tag);
    logic [W-1:0] dif;
    @(negedge clk);
    load = l; done = d; bus = b;
    @(posedge clk);
    dif = b ^ m_prev;
    m_counted = 0;
    m_last_dummy = m_dummy;
    if (l) begin
      m_prev = b; m_acc = 0; m_open = 1; m_valid = 0;
    end else if (m_open) begin
      m_counted = 1;
      m_prev  = b;
      m_acc   = (m_acc + popc(dif) > int'(MAXT)) ? int'(MAXT) : m_acc + popc(dif);
      m_dummy = m_dummy ^ ~dif;
      m_valid = d;
      if (d) begin
        m_open = 0;
        if (m_acc >= int'(THR)) m_flag = 1;
      end
    end else begin
      m_valid = 0;
    end
    #2;
    chk(tag, int'(total), m_acc);
    chk("R5", int'(tvalid), int'(m_valid));
    chk("R6", int'(nsec), int'(m_flag));
    chk("R9", int'(dummy), int'(m_dummy));
    if (m_counted)
      chk("R9", popc(dummy ^ m_last_dummy) + popc(dif), int'(W));
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_ni = 1'b0; load = 0; done = 0; bus = '0;
    m_prev = '0; m_dummy = '0; m_acc = 0; m_open = 0; m_valid = 0; m_flag = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1", int'(total), 0);
    chk("R1", int'(tvalid), 0);
    chk("R1", int'(nsec), 0);
    chk("R1", int'(dummy), 0);
  endtask

  initial begin
    #2_000_000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [W-1:0] lfsr;
    do_reset();

    // quiet window
    step(1, 0, 8'h00, "R2");
    for (int i = 0; i < 9; i++) step(0, 0, 8'h00, "R3");
    step(0, 1, 8'h00, "R4");

    // R6 boundary: total 7 below threshold
    step(1, 0, 8'h00, "R2");
    step(0, 1, 8'h7F, "R6");
    step(0, 0, 8'hAA, "R4");
    step(0, 0, 8'h55, "R4");
    // done outside window ignored (R5)
    step(0, 1, 8'h0F, "R5");
    step(0, 0, 8'h0F, "R5");

    // load and done together: load wins (R2)
    step(1, 1, 8'h01, "R2");
    step(0, 0, 8'h03, "R3");
    step(0, 0, 8'h06, "R3");
    step(0, 1, 8'h0C, "R4");   // total 1+2+2 = 5
    step(0, 0, 8'hF0, "R4");

    // R6 boundary: total exactly 8 sets flag
    step(1, 0, 8'h00, "R2");
    step(0, 1, 8'hFF, "R6");
    step(0, 0, 8'h00, "R4");

    // R7: quiet window keeps flag
    step(1, 0, 8'h3C, "R7");
    for (int i = 0; i < 5; i++) step(0, 0, 8'h3C, "R7");
    step(0, 1, 8'h3C, "R7");
    step(0, 0, 8'h00, "R7");

    // R8: saturation in an overlong full-toggle window
    step(1, 0, 8'h00, "R2");
    for (int i = 0; i < 14; i++) step(0, 0, (i % 2 == 0) ? 8'hFF : 8'h00, "R8");
    step(0, 1, 8'h5A, "R8");
    step(0, 0, 8'hA5, "R8");

    // R1: reset clears flag
    do_reset();

    // sweep: pseudo-random 11-cycle windows
    lfsr = 8'h1D;
    for (int w = 0; w < 60; w++) begin
      for (int c = 0; c < int'(OPC); c++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        step(c == 0, c == int'(OPC) - 1, (w % 5 == 0) ? (lfsr & 8'h01) : lfsr, "R3");
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(0, 0, lfsr, "R4");
    end

    summary();
  end
endmodule